// File: doc/BRIEF.md
# Record/Playback End-of-Message Sequencer

This block walks the page, block and segment addresses of a nonvolatile audio array while an analog message is recorded or played back. A per-sample `tick` advances a position counter inside the current page. A page holds 2048 samples, split into 32 blocks of 64 samples, and every 4 blocks form one end-of-message segment, so each page has 8 segments. A recording or playback always starts at sample 0 of a page chosen by an 11-bit start page. The array has 1888 pages.

Recording can only end on a segment boundary. When a stop arrives during a record, the sequencer keeps going until the current segment is full. It then pulses `eom_wr` so the storage neighbour sets the marker for that page and segment. During playback the sequencer asks for the stored marker at the end of every segment (`eom_query`). If the marker is set, the message is finished. Running off the end of the last page is an overflow. Both events latch a flag and pull the active-low interrupt `irq_n` low, which stays low until a status read clears both flags. At 8 kHz one page is 256 ms and one segment is 32 ms.

Top module: `rp_eom_sequencer`

## Requirements
- R1: After reset the block is idle, page, block and segment addresses are 0, both flags are clear, `irq_n` is 1, and `eom_wr` and `eom_query` are 0.
- R2: In idle, `cmd_rec` or `cmd_play` with `start_page` at most 1887 loads that page and sample position 0, and the matching active output rises on the next cycle. `cmd_rec` wins when both are high. A start page above 1887 has no effect, and neither do start commands while the block is active.
- R3: While the block is active, each `tick` advances the sample position by one. `blk_addr` is the position divided by 64 (0..31). `seg_addr` is the position divided by 256 (0..7). After position 2047 the page increments and the position returns to 0. Cycles without `tick` change nothing.
- R4: A `cmd_stop` during record is held pending. Recording continues until the tick that completes the current segment. In that cycle `eom_wr` is 1 while `page_addr` and `seg_addr` name the finished segment. The block is idle on the next cycle and both addresses hold.
- R5: During playback, `eom_query` is 1 in every cycle where a tick completes a segment and no stop is present. If `eom_bit` is 1 in that cycle, the EOM flag is set and the block goes idle with its addresses held.
- R6: A `cmd_stop` during playback returns the block to idle on the next cycle without a tick advance and without setting a flag.
- R7: When a tick completes position 2047 of page 1887 with no stop ending a record and no marker hit, the overflow flag is set, the block goes idle and `page_addr` stays 1887. A pending record stop on that tick writes the marker instead, and no overflow is raised.
- R8: `irq_n` is 0 whenever the EOM or overflow flag is set. The flags persist until a cycle with `status_rd`, which clears both. A flag set in the same cycle as `status_rd` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One pulse per audio sample |
| cmd_rec | input | 1 | Start recording at `start_page` |
| cmd_play | input | 1 | Start playback at `start_page` |
| cmd_stop | input | 1 | Stop request |
| start_page | input | 11 | Start page for record or play |
| status_rd | input | 1 | Status read; clears both flags |
| eom_bit | input | 1 | Stored marker of the addressed segment |
| page_addr | output | 11 | Current page |
| blk_addr | output | 5 | Current 64-sample block in the page |
| seg_addr | output | 3 | Current end-of-message segment in the page |
| eom_wr | output | 1 | Write the marker of the addressed segment |
| eom_query | output | 1 | Marker of the addressed segment is being sampled |
| rec_active | output | 1 | Recording in progress |
| play_active | output | 1 | Playback in progress |
| eom_flag | output | 1 | Latched end-of-message event |
| ovf_flag | output | 1 | Latched overflow event |
| irq_n | output | 1 | Active-low interrupt, open-drain style |

## Verification
The embedded properties watch the following on every cycle:
- the page address stays inside the array;
- the position freezes without a tick;
- a record stop before a segment end keeps recording alive, and a marker write ends the run with the addresses frozen;
- a marker hit sets the EOM flag, and overflow appears only on the top page;
- a play stop is immediate;
- the interrupt holds until a status read.

Only the scenarios show the exact tick on which a deferred stop lands, the page rollover under gapped ticks, and the round trip where markers written by a record end a later playback at the right segment. They also cover the choice between overflow and marker write on the very last segment, and a flag set during a status read surviving.

// File: rtl/rp_seq_pkg.sv
package rp_seq_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_REC  = 2'd1,
        MODE_PLAY = 2'd2
    } seq_mode_e;
endpackage

// File: rtl/rp_addr_walker.sv
module rp_addr_walker #(
    parameter int NUM_PAGES       = 1888,
    parameter int PAGE_W          = 11,
    parameter int SEGS_PER_PAGE   = 8,
    parameter int BLOCKS_PER_SEG  = 4,
    parameter int TICKS_PER_BLOCK = 64,
    localparam int BLK_W          = $clog2(SEGS_PER_PAGE * BLOCKS_PER_SEG),
    localparam int SEG_W          = $clog2(SEGS_PER_PAGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [PAGE_W-1:0] load_page,
    input  logic              adv,
    output logic [PAGE_W-1:0] page,
    output logic [BLK_W-1:0]  blk,
    output logic [SEG_W-1:0]  seg,
    output logic              seg_last,
    output logic              page_last,
    output logic              at_top
);
    localparam int TB_W       = $clog2(TICKS_PER_BLOCK);
    localparam int CNT_W      = BLK_W + TB_W;
    localparam int SEG_TICKS  = BLOCKS_PER_SEG * TICKS_PER_BLOCK;
    localparam int SEG_TICK_W = $clog2(SEG_TICKS);
    localparam logic [CNT_W-1:0]      CNT_MAX  = CNT_W'(SEGS_PER_PAGE * SEG_TICKS - 1);
    localparam logic [SEG_TICK_W-1:0] SEG_MAX  = SEG_TICK_W'(SEG_TICKS - 1);
    localparam logic [PAGE_W-1:0]     TOP_PAGE = PAGE_W'(NUM_PAGES - 1);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [CNT_W-1:0]  cnt;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (load) begin
            w_d.page = load_page;
            w_d.cnt  = '0;
        end else if (adv) begin
            if (w_q.cnt == CNT_MAX) begin
                w_d.cnt  = '0;
                w_d.page = w_q.page + 1'b1;
            end else begin
                w_d.cnt = w_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign page      = w_q.page;
    assign blk       = w_q.cnt[CNT_W-1:TB_W];
    assign seg       = w_q.cnt[CNT_W-1 -: SEG_W];
    assign seg_last  = (w_q.cnt[SEG_TICK_W-1:0] == SEG_MAX);
    assign page_last = (w_q.cnt == CNT_MAX);
    assign at_top    = (w_q.page == TOP_PAGE);

    // R3
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_q.page <= TOP_PAGE);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(w_q));
endmodule

// File: rtl/rp_event_flags.sv
module rp_event_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_eom,
    input  logic set_ovf,
    input  logic clr,
    output logic eom_flag,
    output logic ovf_flag,
    output logic irq_n
);
    typedef struct packed {
        logic eom;
        logic ovf;
    } flags_t;

    flags_t f_d, f_q;

    always_comb begin
        f_d     = f_q;
        f_d.eom = set_eom | (f_q.eom & ~clr);
        f_d.ovf = set_ovf | (f_q.ovf & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign eom_flag = f_q.eom;
    assign ovf_flag = f_q.ovf;
    assign irq_n    = ~(f_q.eom | f_q.ovf);

    // R8
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set_eom && !set_ovf) |=> irq_n);
endmodule

// File: rtl/rp_eom_sequencer.sv
module rp_eom_sequencer
    import rp_seq_pkg::*;
#(
    parameter int NUM_PAGES       = 1888,
    parameter int PAGE_W          = 11,
    parameter int SEGS_PER_PAGE   = 8,
    parameter int BLOCKS_PER_SEG  = 4,
    parameter int TICKS_PER_BLOCK = 64,
    localparam int BLK_W          = $clog2(SEGS_PER_PAGE * BLOCKS_PER_SEG),
    localparam int SEG_W          = $clog2(SEGS_PER_PAGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_rec,
    input  logic              cmd_play,
    input  logic              cmd_stop,
    input  logic [PAGE_W-1:0] start_page,
    input  logic              status_rd,
    input  logic              eom_bit,
    output logic [PAGE_W-1:0] page_addr,
    output logic [BLK_W-1:0]  blk_addr,
    output logic [SEG_W-1:0]  seg_addr,
    output logic              eom_wr,
    output logic              eom_query,
    output logic              rec_active,
    output logic              play_active,
    output logic              eom_flag,
    output logic              ovf_flag,
    output logic              irq_n
);
    localparam logic [PAGE_W-1:0] TOP_PAGE = PAGE_W'(NUM_PAGES - 1);

    typedef struct packed {
        seq_mode_e mode;
        logic      stop_pend;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic load, adv, set_eom, set_ovf;
    logic seg_last, page_last, at_top;
    logic stop_now, start_ok;

    rp_addr_walker #(
        .NUM_PAGES      (NUM_PAGES),
        .PAGE_W         (PAGE_W),
        .SEGS_PER_PAGE  (SEGS_PER_PAGE),
        .BLOCKS_PER_SEG (BLOCKS_PER_SEG),
        .TICKS_PER_BLOCK(TICKS_PER_BLOCK)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_page(start_page),
        .adv      (adv),
        .page     (page_addr),
        .blk      (blk_addr),
        .seg      (seg_addr),
        .seg_last (seg_last),
        .page_last(page_last),
        .at_top   (at_top)
    );

    rp_event_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_eom (set_eom),
        .set_ovf (set_ovf),
        .clr     (status_rd),
        .eom_flag(eom_flag),
        .ovf_flag(ovf_flag),
        .irq_n   (irq_n)
    );

    assign start_ok = (start_page <= TOP_PAGE);
    assign stop_now = ctl_q.stop_pend | cmd_stop;

    always_comb begin
        ctl_d     = ctl_q;
        load      = 1'b0;
        adv       = 1'b0;
        eom_wr    = 1'b0;
        eom_query = 1'b0;
        set_eom   = 1'b0;
        set_ovf   = 1'b0;
        unique case (ctl_q.mode)
            MODE_IDLE: begin
                ctl_d.stop_pend = 1'b0;
                if (start_ok && cmd_rec) begin
                    ctl_d.mode = MODE_REC;
                    load       = 1'b1;
                end else if (start_ok && cmd_play) begin
                    ctl_d.mode = MODE_PLAY;
                    load       = 1'b1;
                end
            end
            MODE_REC: begin
                ctl_d.stop_pend = stop_now;
                if (tick) begin
                    if (seg_last && stop_now) begin
                        eom_wr     = 1'b1;
                        ctl_d.mode = MODE_IDLE;
                    end else if (page_last && at_top) begin
                        set_ovf    = 1'b1;
                        ctl_d.mode = MODE_IDLE;
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            MODE_PLAY: begin
                if (cmd_stop) begin
                    ctl_d.mode = MODE_IDLE;
                end else if (tick) begin
                    eom_query = seg_last;
                    if (seg_last && eom_bit) begin
                        set_eom    = 1'b1;
                        ctl_d.mode = MODE_IDLE;
                    end else if (page_last && at_top) begin
                        set_ovf    = 1'b1;
                        ctl_d.mode = MODE_IDLE;
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            default: ctl_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: MODE_IDLE, stop_pend: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign rec_active  = (ctl_q.mode == MODE_REC);
    assign play_active = (ctl_q.mode == MODE_PLAY);

    // R4
    stop_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_active && cmd_stop && !(tick && seg_last)) |=> rec_active);

    // R4
    eom_wr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eom_wr |=> (!rec_active && !play_active && $stable(page_addr) && $stable(seg_addr)));

    // R5
    eom_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eom_query && eom_bit) |=> (eom_flag && !play_active));

    // R6
    play_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (play_active && cmd_stop) |=> (!play_active && $stable(blk_addr)));

    // R7
    ovf_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (page_addr == TOP_PAGE));

    // R8
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !status_rd) |=> !irq_n);
endmodule

// File: tb/rp_eom_sequencer_test.sv
module rp_eom_sequencer_test;
    localparam int NP = 1888;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, cmd_rec = 1'b0, cmd_play = 1'b0, cmd_stop = 1'b0;
    logic [10:0] start_page = '0;
    logic        status_rd = 1'b0;
    logic        eom_bit;
    logic [10:0] page_addr;
    logic [4:0]  blk_addr;
    logic [2:0]  seg_addr;
    logic        eom_wr, eom_query, rec_active, play_active, eom_flag, ovf_flag, irq_n;

    bit marks [0:NP*8-1];
    int checks = 0;
    int errors = 0;
    int wr_seen = 0;

    always #4 clk = ~clk;

    rp_eom_sequencer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_rec(cmd_rec), .cmd_play(cmd_play),
        .cmd_stop(cmd_stop), .start_page(start_page), .status_rd(status_rd), .eom_bit(eom_bit),
        .page_addr(page_addr), .blk_addr(blk_addr), .seg_addr(seg_addr), .eom_wr(eom_wr),
        .eom_query(eom_query), .rec_active(rec_active), .play_active(play_active),
        .eom_flag(eom_flag), .ovf_flag(ovf_flag), .irq_n(irq_n)
    );

    // storage neighbour: one marker bit per page segment
    assign eom_bit = marks[int'(page_addr) * 8 + int'(seg_addr)];
    always @(posedge clk) if (eom_wr) marks[int'(page_addr) * 8 + int'(seg_addr)] <= 1'b1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, compared every cycle
    int m_mode = 0, m_page = 0, m_cnt = 0;
    bit m_stop = 0, m_eom = 0, m_ovf = 0;
    initial begin
        forever begin
            bit t, r, p, s, rd, b, seg_end, pend, se, so;
            int sp;
            @(negedge clk);
            #2;
            t = tick; r = cmd_rec; p = cmd_play; s = cmd_stop; rd = status_rd; sp = int'(start_page);
            b = marks[m_page * 8 + m_cnt / 256];
            seg_end = (m_cnt % 256) == 255;
            pend = m_stop || s;
            chk("R3 page_addr", int'(page_addr), m_page);
            chk("R3 blk_addr", int'(blk_addr), m_cnt / 64);
            chk("R3 seg_addr", int'(seg_addr), m_cnt / 256);
            chk("R2 rec_active", int'(rec_active), int'(m_mode == 1));
            chk("R2 play_active", int'(play_active), int'(m_mode == 2));
            chk("R4 eom_wr", int'(eom_wr), int'(m_mode == 1 && t && seg_end && pend));
            chk("R5 eom_query", int'(eom_query), int'(m_mode == 2 && t && seg_end && !s));
            chk("R8 eom_flag", int'(eom_flag), int'(m_eom));
            chk("R8 ovf_flag", int'(ovf_flag), int'(m_ovf));
            chk("R8 irq_n", int'(irq_n), int'(!(m_eom || m_ovf)));
            if (eom_wr) wr_seen++;
            @(posedge clk);
            se = 0; so = 0;
            if (!rst_n) begin
                m_mode = 0; m_page = 0; m_cnt = 0; m_stop = 0; m_eom = 0; m_ovf = 0;
            end else begin
                case (m_mode)
                    0: begin
                        m_stop = 0;
                        if (sp < NP && (r || p)) begin
                            m_mode = r ? 1 : 2; m_page = sp; m_cnt = 0;
                        end
                    end
                    1: begin
                        m_stop = pend;
                        if (t) begin
                            if (seg_end && pend) m_mode = 0;
                            else if (m_cnt == 2047 && m_page == NP - 1) begin so = 1; m_mode = 0; end
                            else if (m_cnt == 2047) begin m_cnt = 0; m_page++; end
                            else m_cnt++;
                        end
                    end
                    default: begin
                        if (s) m_mode = 0;
                        else if (t) begin
                            if (seg_end && b) begin se = 1; m_mode = 0; end
                            else if (m_cnt == 2047 && m_page == NP - 1) begin so = 1; m_mode = 0; end
                            else if (m_cnt == 2047) begin m_cnt = 0; m_page++; end
                            else m_cnt++;
                        end
                    end
                endcase
                m_eom = se || (m_eom && !rd);
                m_ovf = so || (m_ovf && !rd);
            end
        end
    end

    task automatic ticks(input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            if (gap) begin
                tick = 1'b0;
                @(negedge clk);
            end
        end
        tick = 1'b0;
    endtask

    task automatic start(input bit rec, input bit play, input int pg);
        cmd_rec = rec; cmd_play = play; start_page = 11'(pg);
        @(negedge clk);
        cmd_rec = 1'b0; cmd_play = 1'b0;
    endtask

    task automatic pulse_stop(input bit with_tick);
        cmd_stop = 1'b1; tick = with_tick;
        @(negedge clk);
        cmd_stop = 1'b0; tick = 1'b0;
    endtask

    task automatic pulse_rd();
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk("R1 idle", int'(rec_active | play_active), 0);
        chk("R1 irq_n", int'(irq_n), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 out-of-range start pages ignored
        start(1, 0, 1888);
        start(0, 1, 2000);
        #1 chk("R2 bad start ignored", int'(rec_active | play_active), 0);

        // R2 record wins over play; R4 deferred stop
        start(1, 1, 5);
        #1 chk("R2 rec priority", int'(rec_active), 1);
        ticks(100, 0);
        cmd_rec = 1'b1; start_page = 11'd9; tick = 1'b1;
        @(negedge clk);
        cmd_rec = 1'b0; tick = 1'b0;
        #1 chk("R2 start while busy ignored", int'(page_addr), 5);
        ticks(199, 0);
        pulse_stop(1);
        #1 chk("R4 still recording after stop", int'(rec_active), 1);
        ticks(300, 0);
        #1 chk("R4 stopped at segment end", int'(seg_addr), 1);
        chk("R4 one marker written", wr_seen, 1);
        chk("R4 idle after marker", int'(rec_active), 0);

        // R3 page rollover with gapped ticks, then stop without tick
        start(1, 0, 20);
        ticks(1000, 1);
        ticks(1048, 0);
        #1 chk("R3 next page", int'(page_addr), 21);
        chk("R3 segment back to 0", int'(seg_addr), 0);
        pulse_stop(0);
        ticks(300, 0);
        #1 chk("R4 marker page", int'(page_addr), 21);
        chk("R4 second marker", wr_seen, 2);

        // R5 playback ends on stored marker of page 21 segment 0
        start(0, 1, 20);
        ticks(2400, 0);
        #1 chk("R5 eom flag", int'(eom_flag), 1);
        chk("R5 stop page", int'(page_addr), 21);
        chk("R5 idle", int'(play_active), 0);
        repeat (20) @(negedge clk);
        #1 chk("R8 irq held", int'(irq_n), 0);
        pulse_rd();
        #1 chk("R8 cleared by status read", int'(irq_n), 1);

        // R6 immediate stop in playback
        start(0, 1, 5);
        ticks(100, 0);
        pulse_stop(1);
        #1 chk("R6 idle at once", int'(play_active), 0);
        chk("R6 no advance", int'(blk_addr), 1);
        chk("R6 no flag", int'(irq_n), 1);

        // R7 overflow on last page; R8 set wins over simultaneous read
        start(1, 0, 1887);
        status_rd = 1'b1;
        ticks(2048, 0);
        status_rd = 1'b0;
        #1 chk("R7 overflow flag", int'(ovf_flag), 1);
        chk("R7 page held", int'(page_addr), 1887);
        chk("R8 irq on overflow", int'(irq_n), 0);
        pulse_rd();

        // R7 pending stop on final segment writes marker, no overflow
        start(1, 0, 1887);
        ticks(2000, 0);
        pulse_stop(1);
        ticks(100, 0);
        #1 chk("R7 no overflow with stop", int'(ovf_flag), 0);
        chk("R7 marker on last segment", int'(seg_addr), 7);

        // R5 playback of last page hits that marker before overflow
        start(0, 1, 1887);
        ticks(2100, 0);
        #1 chk("R5 eom before overflow", int'(eom_flag), 1);
        chk("R7 no overflow on marker", int'(ovf_flag), 0);
        pulse_rd();
        @(negedge clk);
        finish_run();
    end
endmodule